// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block keeps a small direct-mapped data cache coherent on a shared bus where other agents also write memory. Every line carries a tag and one state bit, valid or invalid. Processor reads that hit are answered from the local array. Reads that miss fetch the whole line over the bus. Every processor write goes straight through to memory as a bus write, whether or not the line is present. Write misses do not allocate a line. The controller watches the bus for writes from other agents. When one lands on any word of a line it holds, it drops that whole line to invalid and puts nothing on the bus in reply.

The processor side has two valid/ready channels. A request is taken when `cpu_req_valid` and `cpu_req_ready` are both high on a clock edge. `cpu_req_ready` is high only while the controller is idle, so the processor is held off for the whole bus transaction. A response stays on `cpu_rsp_valid` with steady data until `cpu_rsp_ready` takes it. Until then no new request is accepted.

On the bus side, the controller raises `bus_req` and waits for `bus_gnt`. It then drives `bus_valid` with the command until the transaction completes. A write completes on one `bus_ack`. A read completes after one `bus_rvalid` beat per word of the line, with the words in ascending order. The snoop inputs show every bus transaction, including the ones this controller issues itself. Those are recognised by their requester ID and do not cause an invalidation.

Top module: `wt_snoop_cache`

## Requirements
- R1: While reset is held, `cpu_req_ready` is 1 and both `cpu_rsp_valid` and `bus_req` are 0. After reset every line is invalid, so the first read of any address misses.
- R2: A read miss issues exactly one bus read to the line-aligned address (word offset bits zero). It takes `LINE_WORDS` read beats, word k on beat k. The line then becomes valid, and the response carries the word at the requested offset.
- R3: A read hit uses no bus transaction. Its response is valid in the cycle after the request is accepted.
- R4: Every processor write issues exactly one bus write carrying the word address and data. The response follows `bus_ack`. A write hit also updates the local copy of that word.
- R5: A write to an address whose line is not held leaves that line invalid, so a later read of it misses.
- R6: A snooped write from another requester ID invalidates the held line whose index and tag match, whatever word of the line it names. A line with the same index but a different tag is unaffected.
- R7: Snooped writes carrying this controller's own ID (`MY_ID`), and all snooped reads, change no line state.
- R8: When a snoop invalidation and a request to the same line arrive in the same cycle, the snoop is applied first, so a read is treated as a miss.
- R9: If another agent writes the line while it is being filled, the fill still answers the request, but the line is left invalid.
- R10: `cpu_req_ready` is high only while no response is pending and no bus request is raised. A response not taken holds `cpu_rsp_valid` and its data steady. `bus_req` stays high from the request until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller accepts a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Read data (0 for writes) |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Command driven on the bus |
| bus_write | output | 1 | 1 = write command, 0 = line read |
| bus_addr | output | ADDR_W | Word address or line base address |
| bus_wdata | output | DATA_W | Write data |
| bus_id | output | ID_W | This requester's ID |
| bus_ack | input | 1 | Write completion |
| bus_rvalid | input | 1 | Read data beat |
| bus_rdata | input | DATA_W | Read data word |
| snp_valid | input | 1 | Observed bus transaction |
| snp_write | input | 1 | Observed transaction is a write |
| snp_addr | input | ADDR_W | Observed word address |
| snp_id | input | ID_W | Observed requester ID |

## Verification
The two hardest cases both depend on timing. One is a foreign write that arrives in the exact cycle a request to the same line is accepted. The other is a foreign write that arrives in the middle of a line fill. For the first, the bench raises the request and the snoop on the same falling edge while the controller is known to be idle. For the second, the bus model injects a foreign snoop write on the second read beat of a chosen fill. In both cases the bench then counts bus reads on the next access to show whether the line survived.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_RESP = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_snoop_filter.sv
module wtc_snoop_filter #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx,
  output logic [TAG_W-1:0]  inv_tag
);
  // Only foreign writes can make a held copy stale; word offset is dropped
  // because the whole line is the coherence unit.
  assign inv_en  = snp_valid && snp_write && (snp_id != MY_ID);
  assign inv_idx = snp_addr[OFF_W +: IDX_W];
  assign inv_tag = snp_addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 11,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [NUM_LINES-1:0] vld_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic                 inv_match;
  logic                 inv_same;

  assign inv_match = inv_en && vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
  // Snoop applied before the lookup: a line dying this cycle never hits.
  assign inv_same  = inv_en && (inv_idx == lk_idx) && (inv_tag == lk_tag);
  assign lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && !inv_same;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end else begin
        if (set_en && set_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= set_tag;
        end
        if ((inv_match && inv_idx == IDX_W'(i)) ||
            (clr_en && clr_idx == IDX_W'(i))) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  a_r6_snoop_kills_line: assert property (@(posedge clk) disable iff (!rst_n)
    inv_match |=> !vld_q[$past(inv_idx)]);

  // R7: no line may drop out except through a foreign write or a miss refill.
  a_r7_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en && !clr_en) |=> (($past(vld_q) & ~vld_q) == '0));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[{rd_idx, rd_off}];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_idx, wr_off}] <= wr_data;
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter int ID_W       = 2,
  parameter logic [ID_W-1:0] MY_ID = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_id,
  input  logic              bus_ack,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  wtc_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [OFF_W-1:0]  beat_q;
  logic              taint_q;

  logic [IDX_W-1:0]  lk_idx, q_idx, inv_idx;
  logic [TAG_W-1:0]  lk_tag, q_tag, inv_tag;
  logic [OFF_W-1:0]  lk_off, q_off;
  logic              lk_hit, inv_en, accept, fill_beat, fill_last, snoop_on_fill;
  logic [DATA_W-1:0] rd_data;
  logic              ds_we;
  logic [IDX_W-1:0]  ds_widx;
  logic [OFF_W-1:0]  ds_woff;
  logic [DATA_W-1:0] ds_wdata;

  assign lk_off = cpu_req_addr[OFF_W-1:0];
  assign lk_idx = cpu_req_addr[OFF_W +: IDX_W];
  assign lk_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign q_off  = addr_q[OFF_W-1:0];
  assign q_idx  = addr_q[OFF_W +: IDX_W];
  assign q_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_ready && cpu_req_valid;
  assign fill_beat     = (state_q == ST_XFER) && !wr_q && bus_rvalid;
  assign fill_last     = fill_beat && (beat_q == LAST_BEAT);
  assign snoop_on_fill = inv_en && (inv_idx == q_idx) && (inv_tag == q_tag);

  wtc_snoop_filter #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_snoop (
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .snp_id(snp_id), .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag)
  );

  wtc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag),
    .clr_en(accept && !cpu_req_write && !lk_hit), .clr_idx(lk_idx),
    .set_en(fill_last && !taint_q && !snoop_on_fill),
    .set_idx(q_idx), .set_tag(q_tag)
  );

  always_comb begin
    ds_we    = 1'b0;
    ds_widx  = q_idx;
    ds_woff  = beat_q;
    ds_wdata = bus_rdata;
    if (accept && cpu_req_write && lk_hit) begin
      ds_we    = 1'b1;
      ds_widx  = lk_idx;
      ds_woff  = lk_off;
      ds_wdata = cpu_req_wdata;
    end else if (fill_beat) begin
      ds_we = 1'b1;
    end
  end

  wtc_data_store #(
    .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rd_idx(lk_idx), .rd_off(lk_off), .rd_data(rd_data),
    .wr_en(ds_we), .wr_idx(ds_widx), .wr_off(ds_woff), .wr_data(ds_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      beat_q  <= '0;
      taint_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          wr_q    <= cpu_req_write;
          addr_q  <= cpu_req_addr;
          wdata_q <= cpu_req_wdata;
          beat_q  <= '0;
          taint_q <= 1'b0;
          rdata_q <= '0;
          if (!cpu_req_write && lk_hit) begin
            rdata_q <= rd_data;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (bus_gnt) state_q <= ST_XFER;
        ST_XFER: begin
          if (!wr_q && snoop_on_fill) taint_q <= 1'b1;
          if (wr_q) begin
            if (bus_ack) state_q <= ST_RESP;
          end else if (bus_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == q_off) rdata_q <= bus_rdata;
            if (beat_q == LAST_BEAT) state_q <= ST_RESP;
          end
        end
        ST_RESP: if (cpu_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_rdata = rdata_q;
  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign bus_valid = (state_q == ST_XFER);
  assign bus_write = wr_q;
  assign bus_addr  = wr_q ? addr_q : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign bus_wdata = wdata_q;
  assign bus_id    = MY_ID;

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> (!cpu_rsp_valid && !bus_req));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cpu_rsp_valid && !(bus_valid && (bus_ack || bus_rvalid))) |=> bus_req);

  a_r3_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && lk_hit) |=> (cpu_rsp_valid && !bus_req));

  a_r4_write_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write) |=> (bus_req && bus_write));
endmodule

// File: tb/wt_snoop_cache_tb.sv
`timescale 1ns/100ps
module wt_snoop_cache_tb;
  localparam logic [1:0] MY = 2'd1;
  localparam logic [1:0] OTHER = 2'd2;

  logic clk = 0, rst_n = 0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 1;
  logic [15:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic bus_req, bus_valid, bus_write;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0] bus_id;
  logic bus_gnt = 0, bus_ack = 0, bus_rvalid = 0;
  logic [31:0] bus_rdata = '0;
  logic snp_valid = 0, snp_write = 0;
  logic [15:0] snp_addr = '0;
  logic [1:0] snp_id = '0;

  always #2.5 clk = ~clk;

  wt_snoop_cache u_dut (.*);

  int checks = 0, errors = 0, n_rsp = 0, n_brd = 0, n_bwr = 0;
  logic [31:0] bmem [256];
  logic [15:0] last_rd_addr, last_wr_addr;
  logic [31:0] last_wr_data;
  logic inject_fill = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid && cpu_rsp_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), cpu_rsp_rdata, exp_q.pop_front());
      n_rsp++;
    end
  end

  // bus model: arbiter, memory, own-write echo on the snoop port
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        @(negedge clk);
        bus_gnt = 1;
        do @(negedge clk); while (!bus_valid);
        if (bus_write) begin
          n_bwr++;
          last_wr_addr = bus_addr;
          last_wr_data = bus_wdata;
          bmem[bus_addr[7:0]] = bus_wdata;
          bus_ack = 1;
          snp_valid = 1; snp_write = 1; snp_addr = bus_addr; snp_id = MY;
          @(negedge clk);
          bus_ack = 0; snp_valid = 0;
        end else begin
          logic [31:0] line [4];
          n_brd++;
          last_rd_addr = bus_addr;
          for (int i = 0; i < 4; i++) line[i] = bmem[bus_addr[7:0] + 8'(i)];
          for (int i = 0; i < 4; i++) begin
            bus_rvalid = 1; bus_rdata = line[i];
            if (inject_fill && i == 1) begin
              snp_valid = 1; snp_write = 1; snp_id = OTHER;
              snp_addr = bus_addr + 16'd2;
              bmem[bus_addr[7:0] + 8'd2] = 32'h5A5A_0002;
            end
            @(negedge clk);
            snp_valid = 0;
          end
          bus_rvalid = 0;
          inject_fill = 0;
        end
        bus_gnt = 0;
      end
    end
  end

  task automatic cpu_op(bit wr, logic [15:0] a, logic [31:0] d, string req,
                        bit with_snp = 0, logic [15:0] sa = '0, logic [31:0] sd = '0);
    int target;
    target = n_rsp + 1;
    if (with_snp) bmem[sa[7:0]] = sd;
    exp_q.push_back(wr ? 32'd0 : bmem[a[7:0]]);
    tag_q.push_back(req);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    if (with_snp) begin
      snp_valid = 1; snp_write = 1; snp_addr = sa; snp_id = OTHER;
    end
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 0; snp_valid = 0;
    while (n_rsp < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic foreign(bit wr, logic [15:0] a, logic [31:0] d);
    if (wr) bmem[a[7:0]] = d;
    snp_valid = 1; snp_write = wr; snp_addr = a; snp_id = OTHER;
    @(negedge clk);
    snp_valid = 0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    report();
  end

  initial begin
    int rd0, wr0;
    for (int i = 0; i < 256; i++) bmem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, cpu_req_ready}, 32'd1);
    chk("R1 no rsp in reset", {31'd0, cpu_rsp_valid}, 32'd0);
    chk("R1 no bus_req in reset", {31'd0, bus_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1/R2: first read misses and fills line 0x40
    rd0 = n_brd;
    cpu_op(0, 16'h0041, 0, "R2 miss data");
    chk("R2 one bus read", n_brd - rd0, 1);
    chk("R2 line aligned addr", {16'd0, last_rd_addr}, 32'h40);

    // R3: hit, no bus
    rd0 = n_brd;
    cpu_op(0, 16'h0043, 0, "R3 hit data");
    chk("R3 no bus read", n_brd - rd0, 0);

    // R4/R7: write hit goes through, own echo ignored, local copy updated
    wr0 = n_bwr;
    cpu_op(1, 16'h0042, 32'hCAFE_0042, "R4 write rsp");
    chk("R4 one bus write", n_bwr - wr0, 1);
    chk("R4 write addr", {16'd0, last_wr_addr}, 32'h42);
    chk("R4 write data", last_wr_data, 32'hCAFE_0042);
    rd0 = n_brd;
    cpu_op(0, 16'h0042, 0, "R4 updated copy");
    chk("R7 own write kept line", n_brd - rd0, 0);

    // R5: write miss no allocate
    wr0 = n_bwr;
    cpu_op(1, 16'h0085, 32'hBEEF_0085, "R5 write rsp");
    chk("R5 bus write on miss", n_bwr - wr0, 1);
    rd0 = n_brd;
    cpu_op(0, 16'h0085, 0, "R5 read after write miss");
    chk("R5 not allocated", n_brd - rd0, 1);

    // R6: foreign write on another word invalidates whole line
    foreign(1, 16'h0043, 32'h1111_0043);
    rd0 = n_brd;
    cpu_op(0, 16'h0041, 0, "R6 refetched data");
    chk("R6 line invalidated", n_brd - rd0, 1);

    // R7: foreign read ignored
    foreign(0, 16'h0040, 0);
    rd0 = n_brd;
    cpu_op(0, 16'h0040, 0, "R7 data");
    chk("R7 snoop read ignored", n_brd - rd0, 0);

    // R6: same index different tag leaves line alone
    foreign(1, 16'h0060, 32'h2222_0060);
    rd0 = n_brd;
    cpu_op(0, 16'h0041, 0, "R6 tag mismatch data");
    chk("R6 tag mismatch kept", n_brd - rd0, 0);

    // R8: same-cycle snoop and read of same line
    rd0 = n_brd;
    cpu_op(0, 16'h0042, 0, "R8 fresh data", 1, 16'h0042, 32'h3333_0042);
    chk("R8 snoop first forces miss", n_brd - rd0, 1);

    // R9: foreign write during fill
    inject_fill = 1;
    cpu_op(0, 16'h00C0, 0, "R9 fill answers");
    rd0 = n_brd;
    cpu_op(0, 16'h00C2, 0, "R9 new data");
    chk("R9 tainted line not kept", n_brd - rd0, 1);

    // R2: conflict replacement
    rd0 = n_brd;
    cpu_op(0, 16'h0041, 0, "R2 refill data");
    chk("R2 replaced line misses", n_brd - rd0, 1);

    // R10: response back-pressure on a hit
    cpu_rsp_ready = 0;
    exp_q.push_back(bmem[8'h43]); tag_q.push_back("R10 held data");
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 16'h0043;
    @(negedge clk);
    cpu_req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 rsp held", {31'd0, cpu_rsp_valid}, 32'd1);
      chk("R10 data stable", cpu_rsp_rdata, bmem[8'h43]);
      chk("R10 not ready", {31'd0, cpu_req_ready}, 32'd0);
      @(negedge clk);
    end
    rd0 = n_rsp;
    cpu_rsp_ready = 1;
    while (n_rsp == rd0) @(negedge clk);
    @(negedge clk);
    chk("R10 ready again", {31'd0, cpu_req_ready}, 32'd1);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule